// File: doc/BRIEF.md
# Parallel Port Handshake Sequencer

This block is the host side of a 16-bit parallel peripheral link. When the host asks for a transfer, it sets the direction line and, for an outbound word, the data lines. It then raises a control strobe and waits for the peripheral's acknowledge flag. The flag reaches the block without any timing relation to its clock. It is synchronized, and a ready-to-busy change of the flag clears the strobe. For an outbound transfer the data goes on the lines first. The strobe follows after a programmable settling delay, counted in steps of `STEP` clock cycles (100 ns at 100 MHz with the default setting). Inbound transfers raise the strobe together with the direction line.

The block supports two handshake disciplines. In full mode a new transfer starts only when the strobe is low and the flag reads ready. In pulse mode the flag's level is ignored and a low strobe is enough. A request that arrives while the interface is not ready is held until the interface becomes ready, and a busy output tells the host that work is outstanding. The strobe output and the flag input can each be inverted at the pins.

Top module: `hs_sequencer`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) leaves the strobe logically low (so `pctl_pin` equals `ctl_inv`), `io_pin` low, `dout` zero, `busy` low and no request pending.
- R2: An inbound transfer (`start_dir`=1) drives `io_pin` high and asserts the strobe on the same clock edge that launches it, with no delay, and leaves `dout` unchanged.
- R3: An outbound transfer (`start_dir`=0) updates `dout` and drives `io_pin` low on its launch edge. The strobe rises exactly `delay_sel`×`STEP` clock edges later (default `STEP`=10), or on the launch edge itself when `delay_sel` is 0.
- R4: The logical flag is `pflg_pin` XOR `flg_inv`, with 1 meaning busy. While the strobe is asserted, a change of the flag pin from ready to busy clears the strobe on the third clock edge after the change. Flag changes before the strobe rises, including during the settling delay, have no effect.
- R5: `ready` is high when the strobe is low and no delay is running. In full mode (`full_mode`=1) the synchronized flag must also read ready. In pulse mode (`full_mode`=0) the flag's level is ignored.
- R6: A request (`start_req` high for one cycle) that cannot launch is held pending and launches on the first cycle `ready` is high. `busy` is high from acceptance until the strobe clears. A request arriving while one is already pending is dropped.
- R7: `pctl_pin` is the logical strobe XOR `ctl_inv`. With `flg_inv`=1 a low flag pin means busy.
- R8: `dout` changes only on the launch edge of an outbound transfer and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_req | input | 1 | One-cycle transfer request |
| start_dir | input | 1 | 1 = inbound to host, 0 = outbound to peripheral |
| start_word | input | W | Word to send on an outbound transfer |
| full_mode | input | 1 | 1 = full handshake, 0 = pulse handshake |
| delay_sel | input | DW | Settling delay in steps of STEP cycles |
| ctl_inv | input | 1 | Invert the strobe pin |
| flg_inv | input | 1 | Invert the flag pin |
| pflg_pin | input | 1 | Peripheral acknowledge flag (asynchronous) |
| pctl_pin | output | 1 | Control strobe pin |
| io_pin | output | 1 | Direction pin, high for inbound |
| dout | output | W | Output data lines |
| ready | output | 1 | Interface can start a new transfer |
| busy | output | 1 | A request is pending or a transfer is in flight |

## Verification
The hardest situations to reach are a flag edge that arrives while the settling counter is still running, and a second request that arrives while the first is still pending. For the pending case, the bench holds the emulated peripheral's flag busy in full mode, issues two requests, and then releases the flag. It checks that only the first word ever reaches the data lines. For the early-edge case, the bench pulses the flag in the middle of a long delay and confirms that the strobe still rises afterwards and stays high until a later acknowledge. A behavioural model that steps once per clock follows every one of these phases and is compared against the outputs on every cycle.

// File: rtl/hs_sequencer.sv
module hs_sequencer #(
  parameter int W    = 16,
  parameter int DW   = 4,
  parameter int STEP = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_req,
  input  logic          start_dir,
  input  logic [W-1:0]  start_word,
  input  logic          full_mode,
  input  logic [DW-1:0] delay_sel,
  input  logic          ctl_inv,
  input  logic          flg_inv,
  input  logic          pflg_pin,
  output logic          pctl_pin,
  output logic          io_pin,
  output logic [W-1:0]  dout,
  output logic          ready,
  output logic          busy
);
  localparam int MAXD = ((1 << DW) - 1) * STEP;
  localparam int CW   = $clog2(MAXD + 1) < 1 ? 1 : $clog2(MAXD + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_STROBE} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic          flg_s1, flg_s2, flg_d;
  logic          pend, pend_dir;
  logic [W-1:0]  pend_word;

  logic          flag_busy, flag_rise, idle, strobe, launch, l_dir;
  logic [W-1:0]  l_word;
  logic [CW-1:0] delay_cycles;

  always_ff @(posedge clk) begin
    if (rst) begin
      flg_s1 <= 1'b0;
      flg_s2 <= 1'b0;
      flg_d  <= 1'b0;
    end else begin
      flg_s1 <= pflg_pin;
      flg_s2 <= flg_s1;
      flg_d  <= flg_s2;
    end
  end

  assign flag_busy    = flg_s2 ^ flg_inv;
  assign flag_rise    = flag_busy & ~(flg_d ^ flg_inv);
  assign idle         = (state == S_IDLE);
  assign strobe       = (state == S_STROBE);
  assign ready        = idle & (~full_mode | ~flag_busy);
  assign launch       = ready & (pend | start_req);
  assign l_dir        = pend ? pend_dir  : start_dir;
  assign l_word       = pend ? pend_word : start_word;
  assign delay_cycles = CW'(delay_sel) * CW'(STEP);
  assign pctl_pin     = strobe ^ ctl_inv;
  assign busy         = pend | ~idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cnt       <= '0;
      io_pin    <= 1'b0;
      dout      <= '0;
      pend      <= 1'b0;
      pend_dir  <= 1'b0;
      pend_word <= '0;
    end else begin
      unique case (state)
        S_WAIT: begin
          if (cnt <= CW'(1)) state <= S_STROBE;
          else               cnt   <= cnt - CW'(1);
        end
        S_STROBE: if (flag_rise) state <= S_IDLE;
        default: ;
      endcase

      if (launch) begin
        io_pin <= l_dir;
        pend   <= 1'b0;
        if (l_dir || delay_cycles == '0) begin
          state <= S_STROBE;
        end else begin
          state <= S_WAIT;
          cnt   <= delay_cycles;
        end
        if (!l_dir) dout <= l_word;
      end else if (start_req && !pend) begin
        pend      <= 1'b1;
        pend_dir  <= start_dir;
        pend_word <= start_word;
      end
    end
  end
endmodule

// File: rtl/hs_sequencer_chk.sv
module hs_sequencer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         io_pin,
  input logic [W-1:0] dout,
  input logic         ready,
  input logic         busy,
  input logic         strobe,
  input logic         idle,
  input logic         flag_rise
);
  assert_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (!strobe && !io_pin && !busy && dout == '0));

  assert_in_no_delay_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(io_pin) |-> strobe);

  assert_clear_on_edge_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(strobe) |-> $past(flag_rise));

  assert_ready_low_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    ready |-> !strobe);

  assert_strobe_busy_R6: assert property (@(posedge clk) disable iff (rst)
    strobe |-> busy);

  assert_dout_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(dout) |-> ($past(idle) && !io_pin));
endmodule

bind hs_sequencer hs_sequencer_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .io_pin(io_pin), .dout(dout), .ready(ready),
  .busy(busy), .strobe(strobe), .idle(idle), .flag_rise(flag_rise)
);

// File: tb/hs_sequencer_tb.sv
`timescale 1ns/100ps
module hs_sequencer_tb;
  localparam int STEP = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_req = 1'b0, start_dir = 1'b0;
  logic [15:0] start_word = '0;
  logic full_mode = 1'b1;
  logic [3:0] delay_sel = '0;
  logic ctl_inv = 1'b0, flg_inv = 1'b0;
  logic flag_l = 1'b0;
  logic pflg_pin;
  logic pctl_pin, io_pin, ready, busy;
  logic [15:0] dout;

  assign pflg_pin = flag_l ^ flg_inv;
  always #2.5 clk = ~clk;

  hs_sequencer u_dut (
    .clk(clk), .rst(rst), .start_req(start_req), .start_dir(start_dir),
    .start_word(start_word), .full_mode(full_mode), .delay_sel(delay_sel),
    .ctl_inv(ctl_inv), .flg_inv(flg_inv), .pflg_pin(pflg_pin),
    .pctl_pin(pctl_pin), .io_pin(io_pin), .dout(dout), .ready(ready), .busy(busy)
  );

  int checks = 0, errors = 0, cycles = 0;
  bit cmp_en = 0, done = 0;

  // behavioural reference: 0 idle, 1 settling, 2 strobe
  int m_state, m_cnt;
  bit m_io, m_pend, m_pdir;
  logic [15:0] m_dout, m_pword;
  bit q[$];

  always @(posedge clk) begin
    bit s2, dd, rise, rdy, go, dir;
    logic [15:0] w;
    if (rst) begin
      m_state = 0; m_cnt = 0; m_io = 0; m_pend = 0; m_pdir = 0;
      m_dout = '0; m_pword = '0; q = '{0, 0, 0};
    end else begin
      s2 = q[1] ^ flg_inv; dd = q[2] ^ flg_inv; rise = s2 && !dd;
      rdy = (m_state == 0) && (!full_mode || !s2);
      go = rdy && (m_pend || start_req);
      dir = m_pend ? m_pdir : start_dir;
      w = m_pend ? m_pword : start_word;
      if (m_state == 1) begin
        if (m_cnt <= 1) m_state = 2; else m_cnt--;
      end else if (m_state == 2 && rise) m_state = 0;
      if (go) begin
        m_io = dir; m_pend = 0;
        if (!dir) m_dout = w;
        if (dir || delay_sel == 0) m_state = 2;
        else begin m_state = 1; m_cnt = delay_sel * STEP; end
      end else if (start_req && !m_pend) begin
        m_pend = 1; m_pdir = start_dir; m_pword = start_word;
      end
      q.push_front(pflg_pin);
      q.pop_back();
    end
  end

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit mr;
    cycles++;
    if (cmp_en) begin
      #1;
      mr = (m_state == 0) && (!full_mode || !(q[1] ^ flg_inv));
      chk(pctl_pin === ((m_state == 2) ^ ctl_inv), "R4 model pctl", pctl_pin, (m_state == 2) ^ ctl_inv);
      chk(io_pin === m_io, "R2 model io", io_pin, m_io);
      chk(dout === m_dout, "R8 model dout", dout, m_dout);
      chk(ready === mr, "R5 model ready", ready, mr);
      chk(busy === (m_pend || m_state != 0), "R6 model busy", busy, m_pend || m_state != 0);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic req(bit dir, logic [15:0] w);
    start_dir = dir; start_word = w; start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
  endtask

  task automatic ack();
    flag_l = 1'b1; step(5);
    flag_l = 1'b0; step(5);
  endtask

  task automatic measure(logic [3:0] d, logic [15:0] w);
    int n = 0;
    delay_sel = d;
    req(1'b0, w);
    while (pctl_pin == ctl_inv && n < 400) begin step(1); n++; end
    chk(n == d * STEP, "R3 strobe delay", n, d * STEP);
    chk(dout == w && !io_pin, "R3 dout/io", dout, w);
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(negedge clk) if (cycles > 20000 && !done) begin
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=0", cycles);
    finish_run();
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    cmp_en = 1;
    chk(pctl_pin == 1'b0 && !io_pin && !busy && dout == 0, "R1 reset state", {pctl_pin, io_pin, busy}, 0);

    // full mode, delayed strobe and acknowledge timing
    step(3);
    measure(4'd2, 16'hA5A5);
    flag_l = 1'b1;
    step(2);
    chk(pctl_pin == 1'b1, "R4 strobe before third edge", pctl_pin, 1);
    step(1);
    chk(pctl_pin == 1'b0, "R4 strobe cleared", pctl_pin, 0);
    chk(ready == 1'b0, "R5 full mode flag busy", ready, 0);
    flag_l = 1'b0;
    step(3);
    chk(ready == 1'b1, "R5 full mode flag ready", ready, 1);

    measure(4'd0, 16'h1234);
    ack();
    measure(4'd15, 16'h2468);
    ack();
    measure(4'd0, 16'h1234);
    ack();

    // inbound
    req(1'b1, 16'hFFFF);
    chk(io_pin && pctl_pin, "R2 inbound strobe immediate", {io_pin, pctl_pin}, 3);
    chk(dout == 16'h1234, "R2 dout kept", dout, 16'h1234);
    ack();

    // pending and dropped second request
    flag_l = 1'b1; step(3);
    req(1'b0, 16'h0BAD);
    chk(busy && !pctl_pin && dout == 16'h1234, "R6 held pending", dout, 16'h1234);
    req(1'b0, 16'hDEAD);
    step(2);
    flag_l = 1'b0; step(3);
    chk(dout == 16'h0BAD && pctl_pin, "R6 pending launched", dout, 16'h0BAD);
    ack(); step(3);
    chk(!busy && dout == 16'h0BAD, "R6 second request dropped", dout, 16'h0BAD);

    // pulse mode
    full_mode = 1'b0;
    flag_l = 1'b1; step(3);
    chk(ready == 1'b1, "R5 pulse mode ignores flag", ready, 1);
    req(1'b0, 16'h5555);
    chk(pctl_pin == 1'b1, "R5 pulse launch with flag busy", pctl_pin, 1);
    step(4);
    chk(pctl_pin == 1'b1, "R4 no edge keeps strobe", pctl_pin, 1);
    flag_l = 1'b0; step(4);
    flag_l = 1'b1; step(3);
    chk(pctl_pin == 1'b0, "R4 fresh edge clears", pctl_pin, 0);
    flag_l = 1'b0; step(4);

    // flag edge during settling delay
    full_mode = 1'b1;
    delay_sel = 4'd5;
    req(1'b0, 16'h00F0);
    step(5);
    flag_l = 1'b1; step(4);
    flag_l = 1'b0; step(4);
    chk(pctl_pin == 1'b0, "R3 still settling", pctl_pin, 0);
    step(45);
    chk(pctl_pin == 1'b1, "R4 early edge ignored", pctl_pin, 1);
    ack();

    // polarity
    ctl_inv = 1'b1; flg_inv = 1'b1; delay_sel = 4'd0;
    step(4);
    chk(pctl_pin == 1'b1, "R7 inverted idle strobe", pctl_pin, 1);
    chk(ready == 1'b1 && pflg_pin == 1'b1, "R7 high pin reads ready", ready, 1);
    req(1'b0, 16'h7777);
    chk(pctl_pin == 1'b0, "R7 inverted active strobe", pctl_pin, 0);
    ack();
    chk(pctl_pin == 1'b1, "R7 low pin acknowledges", pctl_pin, 1);

    step(2);
    finish_run();
  end
endmodule